// File: doc/BRIEF.md
# Two-Level Pending Interrupt Controller

This block collects interrupt requests from up to 32 sources and turns them into two processor request lines, one for normal interrupts (IRQ) and one for fast interrupts (FIQ). Every request is first captured in a latched per-source pending register. A captured request stays there whether or not the source is masked, until software clears it by writing a one to its bit. From the captured requests that are unmasked and routed to IRQ, a fixed-priority selector picks the lowest index. That winner is moved into a second register, which holds at most one bit, and its index is exposed in a read-only offset register.

Software reaches the block through a simple synchronous register port with byte-addressed, word-aligned offsets. Reads are combinational from the registers. After an IRQ service routine, software clears the source's latched bit and then the service bit. If the latched bit is left set, the same request is selected again as soon as the service register empties. Sources routed to FIQ drive the FIQ line directly from their latched, unmasked bits and never enter the service register.

Top module: `pend_intc`

## Requirements
- R1: A high `src_req` bit in a cycle sets the matching source-pending bit at the next clock edge, whatever the mask holds; the bit reads back at offset 0x00.
- R2: A write to offset 0x00 clears exactly the source-pending bits written as 1 and leaves the bits written as 0. When a clear and a new request hit the same bit in one cycle, the bit ends up set.
- R3: The mask register (offset 0x08) resets to all ones. A mask bit of 1 keeps its source out of both IRQ selection and the FIQ line; 0 lets it through.
- R4: The mode register (offset 0x04, reset 0) routes each source: 0 to IRQ selection, 1 to FIQ. `fiq_o` is high while any latched, unmasked, FIQ-routed bit is set, with no extra register stage.
- R5: While the service register (offset 0x10) is zero, the lowest-index source that is latched, unmasked and IRQ-routed is loaded into it at the next clock edge, as a single bit at that source's position.
- R6: The service register never holds more than one set bit. A non-zero value stays unchanged until a write of ones to offset 0x10 clears it, even if a higher-priority request arrives.
- R7: The offset register (offset 0x14, read-only, reset 0) holds the index of the set service bit, and 0 when the service register is empty. Writes to it have no effect.
- R8: `irq_o` is high exactly while the service register is non-zero.
- R9: A source whose latched bit is still set when its service bit is cleared is selected again. `irq_o` drops for one cycle and then rises again with the same offset.
- R10: Writable registers read back what was written. Reads of offsets other than 0x00, 0x04, 0x08, 0x10 and 0x14 return zero.
- R11: After reset the source-pending, mode, service and offset registers read zero, the mask reads all ones, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Per-source request, sampled each cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The selection path is driven with several request patterns: a single source, two far-apart sources, the same pair with the lower one masked, a mix of FIQ- and IRQ-routed sources, a masked-only request, an FIQ-only request, and all sources with the lower half masked. Between them these patterns separate a lowest-index choice from a highest-index choice, show that masking and routing both filter the candidates, and show that latching ignores the mask. Directed sequences then cover partial clears, a clear and a request in the same cycle, a service bit held against a higher-priority arrival, re-selection after an incomplete service, and the read-only and unmapped offsets.

// File: rtl/pend_intc_pkg.sv
package pend_intc_pkg;
   localparam int unsigned MAP_ADDR_W = 8;
   localparam logic [MAP_ADDR_W-1:0] OFF_SRCPEND = 8'h00;
   localparam logic [MAP_ADDR_W-1:0] OFF_ROUTE   = 8'h04;
   localparam logic [MAP_ADDR_W-1:0] OFF_BLOCK   = 8'h08;
   localparam logic [MAP_ADDR_W-1:0] OFF_SERVICE = 8'h10;
   localparam logic [MAP_ADDR_W-1:0] OFF_INDEX   = 8'h14;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SRCPEND,
      SEL_ROUTE,
      SEL_BLOCK,
      SEL_SERVICE,
      SEL_INDEX
   } reg_sel_e;
endpackage

// File: rtl/pend_intc_latch.sv
module pend_intc_latch #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_en_i,
   input  logic [WIDTH-1:0] clr_bits_i,
   output logic [WIDTH-1:0] pend_o
);
   logic [WIDTH-1:0] clr_eff;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pend_intc_latch: WIDTH must be at least 1");
      end
   endgenerate

   assign clr_eff = clr_en_i ? clr_bits_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_eff) | set_i;
   end

   AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & $past(set_i)) == $past(set_i)))
      else $error("request not latched"); // R1

   AST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~pend_o & $past(pend_o & ~clr_eff)) == '0))
      else $error("pending bit lost without clear"); // R2
endmodule

// File: rtl/pend_intc_prio.sv
module pend_intc_prio #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] cand_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (cand_i[i]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/pend_intc_svc.sv
module pend_intc_svc #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cand_i,
   input  logic             clr_en_i,
   input  logic [WIDTH-1:0] clr_bits_i,
   output logic [WIDTH-1:0] svc_o,
   output logic [IDX_W-1:0] idx_o
);
   logic             hit;
   logic [IDX_W-1:0] win_idx;
   logic [WIDTH-1:0] svc_after_clr;
   logic             clr_hits;

   pend_intc_prio #(.WIDTH(WIDTH)) u_prio (
      .cand_i (cand_i),
      .hit_o  (hit),
      .idx_o  (win_idx)
   );

   assign svc_after_clr = svc_o & ~(clr_en_i ? clr_bits_i : '0);
   assign clr_hits      = (svc_after_clr != svc_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         svc_o <= '0;
         idx_o <= '0;
      end else if (svc_o == '0) begin
         if (hit) begin
            svc_o <= WIDTH'(1) << win_idx;
            idx_o <= win_idx;
         end
      end else begin
         svc_o <= svc_after_clr;
         if (svc_after_clr == '0) idx_o <= '0;
      end
   end

   AST_SVC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(svc_o))
      else $error("service register holds several bits"); // R6

   AST_SVC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_o != '0 && !clr_hits) |=> $stable(svc_o))
      else $error("service register changed without clear"); // R6

   AST_SVC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_o == '0 && hit) |=> (svc_o != '0))
      else $error("winner not loaded into empty service register"); // R5

   AST_IDX_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_o != '0) |-> svc_o[idx_o])
      else $error("offset does not point at service bit"); // R7

   AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_o == '0) |-> (idx_o == '0))
      else $error("offset non-zero while idle"); // R7
endmodule

// File: rtl/pend_intc.sv
module pend_intc
   import pend_intc_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = MAP_ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   generate
      if (N_SRC < 2 || N_SRC > DATA_W) begin : g_bad_src
         $error("pend_intc: N_SRC must lie in 2..DATA_W");
      end
      if (ADDR_W < MAP_ADDR_W) begin : g_bad_addr
         $error("pend_intc: ADDR_W too narrow for register map");
      end
   endgenerate

   reg_sel_e         sel;
   logic [N_SRC-1:0] wdat;
   logic [N_SRC-1:0] srcpend;
   logic [N_SRC-1:0] route_q;
   logic [N_SRC-1:0] block_q;
   logic [N_SRC-1:0] svc;
   logic [IDX_W-1:0] svc_idx;
   logic [N_SRC-1:0] irq_cand;
   logic [N_SRC-1:0] fiq_cand;

   assign wdat = bus_wdata[N_SRC-1:0];

   always_comb begin
      unique case (bus_addr)
         ADDR_W'(OFF_SRCPEND): sel = SEL_SRCPEND;
         ADDR_W'(OFF_ROUTE):   sel = SEL_ROUTE;
         ADDR_W'(OFF_BLOCK):   sel = SEL_BLOCK;
         ADDR_W'(OFF_SERVICE): sel = SEL_SERVICE;
         ADDR_W'(OFF_INDEX):   sel = SEL_INDEX;
         default:              sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_q <= '0;
         block_q <= '1;
      end else if (bus_we) begin
         if (sel == SEL_ROUTE) route_q <= wdat;
         if (sel == SEL_BLOCK) block_q <= wdat;
      end
   end

   pend_intc_latch #(.WIDTH(N_SRC)) u_srcpend (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (src_req),
      .clr_en_i   (bus_we && sel == SEL_SRCPEND),
      .clr_bits_i (wdat),
      .pend_o     (srcpend)
   );

   assign irq_cand = srcpend & ~block_q & ~route_q;
   assign fiq_cand = srcpend & ~block_q & route_q;

   pend_intc_svc #(.WIDTH(N_SRC)) u_svc (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand_i     (irq_cand),
      .clr_en_i   (bus_we && sel == SEL_SERVICE),
      .clr_bits_i (wdat),
      .svc_o      (svc),
      .idx_o      (svc_idx)
   );

   assign irq_o = |svc;
   assign fiq_o = |fiq_cand;

   always_comb begin
      unique case (sel)
         SEL_SRCPEND: bus_rdata = DATA_W'(srcpend);
         SEL_ROUTE:   bus_rdata = DATA_W'(route_q);
         SEL_BLOCK:   bus_rdata = DATA_W'(block_q);
         SEL_SERVICE: bus_rdata = DATA_W'(svc);
         SEL_INDEX:   bus_rdata = DATA_W'(svc_idx);
         default:     bus_rdata = '0;
      endcase
   end

   AST_FIQ_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> (block_q != '1))
      else $error("fast request while every source blocked"); // R3

   AST_IRQ_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && (irq_cand != '0)) |=> irq_o)
      else $error("normal request not raised after selection"); // R8
endmodule

// File: tb/pend_intc_tb_top.sv
module pend_intc_tb_top;
   localparam int unsigned NV = 7;

   localparam logic [31:0] V_REQ  [NV] = '{32'h0000_0001, 32'h8000_0010, 32'h8000_0010,
                                          32'h0000_000F, 32'h0000_0100, 32'h0000_0100,
                                          32'hFFFF_FFFF};
   localparam logic [31:0] V_MASK [NV] = '{32'h0, 32'h0, 32'h0000_0010, 32'h0,
                                          32'h0000_0100, 32'h0, 32'h0000_FFFF};
   localparam logic [31:0] V_MODE [NV] = '{32'h0, 32'h0, 32'h0, 32'h0000_0003,
                                          32'h0, 32'h0000_0100, 32'h0};
   localparam int          V_OFS  [NV] = '{0, 4, 31, 2, 0, 0, 16};
   localparam bit          V_IRQ  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
   localparam bit          V_FIQ  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_req = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        fiq_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pend_intc dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_req   (src_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .fiq_o     (fiq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] r);
      @(negedge clk);
      src_req = r;
      @(negedge clk);
      src_req = '0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      rd("R11 srcpend", 8'h00, 32'h0);
      rd("R11 mode", 8'h04, 32'h0);
      rd("R11 mask", 8'h08, 32'hFFFF_FFFF);
      rd("R11 service", 8'h10, 32'h0);
      rd("R11 offset", 8'h14, 32'h0);
      check("R11 irq", {31'b0, irq_o}, 32'h0);
      check("R11 fiq", {31'b0, fiq_o}, 32'h0);

      // Vector table: R1 R3 R4 R5 R7 R8
      for (int v = 0; v < NV; v++) begin
         wr(8'h08, V_MASK[v]);
         wr(8'h04, V_MODE[v]);
         pulse(V_REQ[v]);
         @(negedge clk);
         rd("R1 srcpend latched", 8'h00, V_REQ[v]);
         rd("R7 offset", 8'h14, 32'(V_OFS[v]));
         rd("R5 service", 8'h10, V_IRQ[v] ? (32'h1 << V_OFS[v]) : 32'h0);
         check("R8 irq", {31'b0, irq_o}, {31'b0, V_IRQ[v]});
         check("R4 fiq", {31'b0, fiq_o}, {31'b0, V_FIQ[v]});
         wr(8'h00, 32'hFFFF_FFFF);
         wr(8'h10, 32'hFFFF_FFFF);
      end
      @(negedge clk);
      check("R6 cleared idle irq", {31'b0, irq_o}, 32'h0);

      // R2 partial clear
      wr(8'h08, 32'hFFFF_FFFF);
      pulse(32'h0000_000F);
      check("R3 masked no fiq", {31'b0, fiq_o}, 32'h0);
      wr(8'h00, 32'h0000_0005);
      rd("R2 partial clear", 8'h00, 32'h0000_000A);

      // R2 clear and request on same bit in one cycle
      @(negedge clk);
      src_req = 32'h2; bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h2;
      @(negedge clk);
      src_req = '0; bus_we = 1'b0;
      rd("R2 request beats clear", 8'h00, 32'h0000_000A);
      wr(8'h00, 32'hFFFF_FFFF);

      // R6 hold against higher priority, R9 re-selection
      wr(8'h04, 32'h0);
      wr(8'h08, 32'hFFFF_FFF5);
      pulse(32'h8);
      @(negedge clk);
      rd("R5 load bit3", 8'h14, 32'd3);
      pulse(32'h2);
      @(negedge clk);
      rd("R6 hold service", 8'h10, 32'h8);
      rd("R6 hold offset", 8'h14, 32'd3);
      wr(8'h10, 32'h8);
      check("R9 irq drops", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      rd("R5 lowest after clear", 8'h14, 32'd1);
      wr(8'h00, 32'h2);
      wr(8'h10, 32'h2);
      check("R9 irq gap", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      rd("R9 re-raised offset", 8'h14, 32'd3);
      check("R9 re-raised irq", {31'b0, irq_o}, 32'h1);

      // R7 offset read-only
      wr(8'h14, 32'h0000_001F);
      rd("R7 offset write ignored", 8'h14, 32'd3);

      // R10 map
      rd("R10 unmapped 0x0C", 8'h0C, 32'h0);
      rd("R10 unmapped 0x18", 8'h18, 32'h0);
      wr(8'h04, 32'h1234_5678);
      rd("R10 mode readback", 8'h04, 32'h1234_5678);
      rd("R10 mask readback", 8'h08, 32'hFFFF_FFF5);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule